// File: doc/BRIEF.md
# Dual-Processor Mailbox Signaling Controller

This block lets two processors signal each other without blocking. There are six channels. Each channel has one one-way subchannel in each direction, and each subchannel holds one occupied/free flag. That gives twelve flags in all. The message data itself lives in shared memory outside the block. The flags only say whether a slot holds an unread message (occupied) or is ready for a new one (free).

Each processor has its own register bank on a simple memory-mapped port. Through that port a processor can:
- occupy the flags it sends on;
- free the flags it receives on;
- set two global interrupt enables;
- program one mask bit per subchannel for each interrupt kind.

Each processor has two interrupt lines. The receive-occupied line tells it that a message is waiting. The transmit-free line tells it that a slot it sends on has been drained. Each line is formed by masking the flags and ORing the result across all channels, and is then registered.

Every flag has exactly one owner for each transition. Only the sender can take it from free to occupied, and only the receiver can take it from occupied to free. This makes each post and each acknowledge atomic, with no read-modify-write.

Top module: `mbx_sig_ctrl`

## Requirements
- R1: After reset, the block is in this state:
  - all twelve flags read free;
  - both mask registers read 0x003F003F, meaning every subchannel is masked;
  - both control registers read 0;
  - all four interrupt outputs are low.
- R2: A write to a processor's set register (word address 3) occupies that processor's transmit flags. Each 1 in bits [21:16] occupies the transmit flag of the same channel. The change shows in the status register of both processors from the next cycle on. A 0 bit leaves its flag unchanged.
- R3: A write to a processor's clear register (word address 2) frees that processor's receive flags. Each 1 in bits [5:0] frees the receive flag of the same channel. A 0 bit leaves its flag unchanged.
- R4: A processor cannot change the flags that the other processor owns for a given transition:
  - its set register never occupies one of its receive flags;
  - its clear register never frees one of its transmit flags.
- R5: Both processors may target the same flag in the same cycle, one with a set and the other with a clear. The flag is then occupied afterwards, whether it was free or occupied before. A clear issued in a later cycle frees it.
- R6: Receive-occupied interrupt, per processor:
  - it is high while the receive-occupied enable (control bit 0) is 1 and at least one receive flag is occupied with its mask bit (mask bits [21:16]) at 0;
  - it follows its condition one cycle after the flag, mask or enable register changes.
- R7: Transmit-free interrupt, per processor:
  - it is high while the transmit-free enable (control bit 16) is 1 and at least one transmit flag is free with its mask bit (mask bits [5:0]) at 0;
  - it follows its condition one cycle after the flag, mask or enable register changes.
- R8: The control register (word address 0) and the mask register (word address 1) read back what was written to their defined bits. All other bits read 0. Word addresses 2, 3, 5, 6 and 7 read 0. Read data appears on the cycle after the read request.
- R9: The status register sits at word address 4. It shows the processor's transmit flags in bits [5:0] and its receive flags in bits [21:16], with 1 meaning occupied. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| p1_req | input | 1 | Processor 1 access request |
| p1_we | input | 1 | Processor 1 write enable (0 = read) |
| p1_addr | input | 3 | Processor 1 word address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data, registered |
| p2_req | input | 1 | Processor 2 access request |
| p2_we | input | 1 | Processor 2 write enable (0 = read) |
| p2_addr | input | 3 | Processor 2 word address |
| p2_wdata | input | 32 | Processor 2 write data |
| p2_rdata | output | 32 | Processor 2 read data, registered |
| p1_irq_rxo | output | 1 | Processor 1 receive-occupied interrupt |
| p1_irq_txf | output | 1 | Processor 1 transmit-free interrupt |
| p2_irq_rxo | output | 1 | Processor 2 receive-occupied interrupt |
| p2_irq_txf | output | 1 | Processor 2 transmit-free interrupt |

## Verification
Directed sequences come first:
- single sets and clears with mixed 0 and 1 bits, which show that a 0 bit has no effect;
- writes that each processor sends to the wrong register for a flag, which show that a flag has one owner per transition;
- same-cycle set/clear pairs on a flag that starts free and on one that starts occupied, which show the conflict priority;
- enable and mask changes watched edge by edge, which separate the one-cycle interrupt latency from combinational behaviour.

A random phase follows. It issues writes from either processor to every address, including the read-only status word, with random data. In about a quarter of the steps both ports write at once. After every step, the status words and all four interrupt lines are compared with a bench model. This exposes any cross-coupling between channels, directions or the two register banks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_MASK = 3'd1,
      SEL_CLR  = 3'd2,
      SEL_SET  = 3'd3,
      SEL_STAT = 3'd4
   } mbx_sel_e;

   // bit offsets of the low and high fields in every bank word
   localparam int FLD_LO = 0;
   localparam int FLD_HI = 16;
endpackage

// File: rtl/mbx_flag_bank.sv
// One direction of subchannel flags: occupied by the sender, freed by the receiver.
module mbx_flag_bank #(
   parameter int NCH = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] occ_req,
   input  logic [NCH-1:0] free_req,
   output logic [NCH-1:0] flags
);
   if (NCH < 1) begin : g_bad_nch
      $error("mbx_flag_bank: NCH must be at least 1");
   end

   for (genvar i = 0; i < NCH; i++) begin : g_flag
      logic f_q;

      // a same-cycle occupy beats a free: the free must come in a later cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            f_q <= 1'b0;
         else if (occ_req[i])   f_q <= 1'b1;
         else if (free_req[i])  f_q <= 1'b0;
      end
      assign flags[i] = f_q;

      // R2 / R4: only the sender can take a flag from free to occupied
      p_occ_by_sender_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!flags[i] && !occ_req[i]) |=> !flags[i]);
      // R3 / R4: only the receiver can take a flag from occupied to free
      p_free_by_receiver_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !free_req[i]) |=> flags[i]);
      // R5: a same-cycle conflict leaves the flag occupied
      p_conflict_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (occ_req[i] && free_req[i]) |=> flags[i]);
   end
endmodule

// File: rtl/mbx_irq_merge.sv
// Masks a flag vector, ORs it across channels, gates it with an enable.
module mbx_irq_merge #(
   parameter int NCH         = 6,
   parameter bit HIT_ON_OCC  = 1'b1,  // 1: occupied flags request, 0: free flags request
   parameter bit OUT_REG     = 1'b1   // 1: registered output, 0: combinational
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           enable,
   input  logic [NCH-1:0] flags,
   input  logic [NCH-1:0] mask,
   output logic           irq
);
   logic [NCH-1:0] hit;
   logic           raw;

   if (HIT_ON_OCC) begin : g_occ
      assign hit = flags;
   end else begin : g_free
      assign hit = ~flags;
   end

   assign raw = enable & (|(hit & ~mask));

   if (OUT_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= raw;
      end
      assign irq = irq_q;

      // R6 / R7: a disabled line is low one cycle later
      p_irq_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !enable |=> !irq);
      // R6 / R7: with no unmasked requesting flag the line drops one cycle later
      p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ((hit & ~mask) == '0) |=> !irq);
      // R6 / R7: an enabled, unmasked request raises the line one cycle later
      p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (enable && ((hit & ~mask) != '0)) |=> irq);
   end else begin : g_comb
      assign irq = raw;
   end
endmodule

// File: rtl/mbx_regbank.sv
// Per-processor register bank: control, mask, clear, set, status.
module mbx_regbank #(
   parameter int NCH = 6,
   parameter int AW  = 3,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req,
   input  logic           we,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   input  logic [NCH-1:0] tx_flags,
   input  logic [NCH-1:0] rx_flags,
   output logic [NCH-1:0] occ_tx,
   output logic [NCH-1:0] free_rx,
   output logic           rxo_en,
   output logic           txf_en,
   output logic [NCH-1:0] rxo_mask,
   output logic [NCH-1:0] txf_mask
);
   import mbx_pkg::*;

   localparam logic [AW-1:0] A_CTRL = AW'(SEL_CTRL);
   localparam logic [AW-1:0] A_MASK = AW'(SEL_MASK);
   localparam logic [AW-1:0] A_CLR  = AW'(SEL_CLR);
   localparam logic [AW-1:0] A_SET  = AW'(SEL_SET);
   localparam logic [AW-1:0] A_STAT = AW'(SEL_STAT);

   if (NCH > FLD_HI) begin : g_bad_nch
      $error("mbx_regbank: NCH must fit below the high field");
   end
   if (DW < FLD_HI + NCH) begin : g_bad_dw
      $error("mbx_regbank: DW too narrow for the high field");
   end
   if (AW < 3) begin : g_bad_aw
      $error("mbx_regbank: AW must be at least 3");
   end

   logic           wr_hit, rd_hit;
   logic           rxo_en_q, txf_en_q;
   logic [NCH-1:0] rxo_mask_q, txf_mask_q;
   logic [DW-1:0]  rd_val, rdata_q;
   logic           unused_wbits;

   assign wr_hit = req & we;
   assign rd_hit = req & ~we;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxo_en_q <= 1'b0;
         txf_en_q <= 1'b0;
      end else if (wr_hit && addr == A_CTRL) begin
         rxo_en_q <= wdata[FLD_LO];
         txf_en_q <= wdata[FLD_HI];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txf_mask_q <= '1;
         rxo_mask_q <= '1;
      end else if (wr_hit && addr == A_MASK) begin
         txf_mask_q <= wdata[FLD_LO +: NCH];
         rxo_mask_q <= wdata[FLD_HI +: NCH];
      end
   end

   // one-cycle request pulses toward the flag banks; 0 bits request nothing
   assign occ_tx  = (wr_hit && addr == A_SET) ? wdata[FLD_HI +: NCH] : '0;
   assign free_rx = (wr_hit && addr == A_CLR) ? wdata[FLD_LO +: NCH] : '0;

   always_comb begin
      rd_val = '0;
      case (addr)
         A_CTRL: begin
            rd_val[FLD_LO] = rxo_en_q;
            rd_val[FLD_HI] = txf_en_q;
         end
         A_MASK: begin
            rd_val[FLD_LO +: NCH] = txf_mask_q;
            rd_val[FLD_HI +: NCH] = rxo_mask_q;
         end
         A_STAT: begin
            rd_val[FLD_LO +: NCH] = tx_flags;
            rd_val[FLD_HI +: NCH] = rx_flags;
         end
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_hit) rdata_q <= rd_val;
   end

   assign rdata    = rdata_q;
   assign rxo_en   = rxo_en_q;
   assign txf_en   = txf_en_q;
   assign rxo_mask = rxo_mask_q;
   assign txf_mask = txf_mask_q;

   // R8: masks only change through a write to the mask word
   p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && addr == A_MASK) |=> ($stable(rxo_mask_q) && $stable(txf_mask_q)));
   // R8: enables only change through a write to the control word
   p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && addr == A_CTRL) |=> ($stable(rxo_en_q) && $stable(txf_en_q)));
   // R4: set and clear pulses never come from one access
   p_one_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !((occ_tx != '0) && (free_rx != '0)));
endmodule

// File: rtl/mbx_sig_ctrl.sv
// Two-processor mailbox signaling: flags, per-processor banks, merged interrupts.
module mbx_sig_ctrl #(
   parameter int NCH     = 6,
   parameter int AW      = 3,
   parameter int DW      = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          p1_req,
   input  logic          p1_we,
   input  logic [AW-1:0] p1_addr,
   input  logic [DW-1:0] p1_wdata,
   output logic [DW-1:0] p1_rdata,
   input  logic          p2_req,
   input  logic          p2_we,
   input  logic [AW-1:0] p2_addr,
   input  logic [DW-1:0] p2_wdata,
   output logic [DW-1:0] p2_rdata,
   output logic          p1_irq_rxo,
   output logic          p1_irq_txf,
   output logic          p2_irq_rxo,
   output logic          p2_irq_txf
);
   localparam int NPROC = 2;

   // index d of flag_v: direction sent by processor d (0 = to 2, 1 = to 1)
   logic [NCH-1:0] flag_v   [NPROC];
   logic [NCH-1:0] occ_v    [NPROC];
   logic [NCH-1:0] free_v   [NPROC];
   logic [NCH-1:0] rxo_m_v  [NPROC];
   logic [NCH-1:0] txf_m_v  [NPROC];
   logic           rxo_en_v [NPROC];
   logic           txf_en_v [NPROC];
   logic           irq_rxo_v[NPROC];
   logic           irq_txf_v[NPROC];
   logic           req_v    [NPROC];
   logic           we_v     [NPROC];
   logic [AW-1:0]  addr_v   [NPROC];
   logic [DW-1:0]  wdata_v  [NPROC];
   logic [DW-1:0]  rdata_v  [NPROC];

   assign req_v[0]   = p1_req;
   assign we_v[0]    = p1_we;
   assign addr_v[0]  = p1_addr;
   assign wdata_v[0] = p1_wdata;
   assign req_v[1]   = p2_req;
   assign we_v[1]    = p2_we;
   assign addr_v[1]  = p2_addr;
   assign wdata_v[1] = p2_wdata;

   for (genvar p = 0; p < NPROC; p++) begin : g_proc
      localparam int PEER = NPROC - 1 - p;

      mbx_regbank #(.NCH(NCH), .AW(AW), .DW(DW)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (req_v[p]),
         .we       (we_v[p]),
         .addr     (addr_v[p]),
         .wdata    (wdata_v[p]),
         .rdata    (rdata_v[p]),
         .tx_flags (flag_v[p]),
         .rx_flags (flag_v[PEER]),
         .occ_tx   (occ_v[p]),
         .free_rx  (free_v[PEER]),
         .rxo_en   (rxo_en_v[p]),
         .txf_en   (txf_en_v[p]),
         .rxo_mask (rxo_m_v[p]),
         .txf_mask (txf_m_v[p])
      );

      // direction p: occupied by processor p, freed by its peer
      mbx_flag_bank #(.NCH(NCH)) u_flags (
         .clk      (clk),
         .rst_n    (rst_n),
         .occ_req  (occ_v[p]),
         .free_req (free_v[p]),
         .flags    (flag_v[p])
      );

      mbx_irq_merge #(.NCH(NCH), .HIT_ON_OCC(1'b1), .OUT_REG(IRQ_REG)) u_rxo (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (rxo_en_v[p]),
         .flags  (flag_v[PEER]),
         .mask   (rxo_m_v[p]),
         .irq    (irq_rxo_v[p])
      );

      mbx_irq_merge #(.NCH(NCH), .HIT_ON_OCC(1'b0), .OUT_REG(IRQ_REG)) u_txf (
         .clk    (clk),
         .rst_n  (rst_n),
         .enable (txf_en_v[p]),
         .flags  (flag_v[p]),
         .mask   (txf_m_v[p]),
         .irq    (irq_txf_v[p])
      );
   end

   assign p1_rdata   = rdata_v[0];
   assign p2_rdata   = rdata_v[1];
   assign p1_irq_rxo = irq_rxo_v[0];
   assign p1_irq_txf = irq_txf_v[0];
   assign p2_irq_rxo = irq_rxo_v[1];
   assign p2_irq_txf = irq_txf_v[1];

   // R1: all interrupts are low on the first cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !(p1_irq_rxo || p1_irq_txf || p2_irq_rxo || p2_irq_txf));
endmodule

// File: tb/sim_mbx_sig_ctrl.sv
`timescale 1ns/1ps
module sim_mbx_sig_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p1_req = 0, p1_we = 0, p2_req = 0, p2_we = 0;
   logic [2:0]  p1_addr = 0, p2_addr = 0;
   logic [31:0] p1_wdata = 0, p2_wdata = 0;
   logic [31:0] p1_rdata, p2_rdata;
   logic        p1_irq_rxo, p1_irq_txf, p2_irq_rxo, p2_irq_txf;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // bench model: m_flag[d] is the direction sent by processor d
   logic [5:0] m_flag [2];
   logic       m_rxen [2];
   logic       m_txen [2];
   logic [5:0] m_rxmk [2];
   logic [5:0] m_txmk [2];

   always #2.5 clk = ~clk;

   mbx_sig_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
      .p2_req(p2_req), .p2_we(p2_we), .p2_addr(p2_addr), .p2_wdata(p2_wdata), .p2_rdata(p2_rdata),
      .p1_irq_rxo(p1_irq_rxo), .p1_irq_txf(p1_irq_txf),
      .p2_irq_rxo(p2_irq_rxo), .p2_irq_txf(p2_irq_txf)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
      end
   endtask

   task automatic drive(input int p, input logic r, input logic w, input logic [2:0] a,
                        input logic [31:0] d);
      if (p == 0) begin
         p1_req = r; p1_we = w; p1_addr = a; p1_wdata = d;
      end else begin
         p2_req = r; p2_we = w; p2_addr = a; p2_wdata = d;
      end
   endtask

   function automatic logic [31:0] exp_stat(input int p);
      return {10'd0, m_flag[1-p], 10'd0, m_flag[p]};
   endfunction

   function automatic logic exp_rxo(input int p);
      return m_rxen[p] & (|(m_flag[1-p] & ~m_rxmk[p]));
   endfunction

   function automatic logic exp_txf(input int p);
      return m_txen[p] & (|(~m_flag[p] & ~m_txmk[p]));
   endfunction

   // model update for one cycle in which either or both ports may write
   task automatic model_step(input bit v0, input logic [2:0] a0, input logic [31:0] d0,
                             input bit v1, input logic [2:0] a1, input logic [31:0] d1);
      logic [5:0] s [2];
      logic [5:0] c [2];
      bit         v [2];
      logic [2:0] a [2];
      logic [31:0] d [2];
      v[0] = v0; a[0] = a0; d[0] = d0;
      v[1] = v1; a[1] = a1; d[1] = d1;
      for (int q = 0; q < 2; q++) begin s[q] = '0; c[q] = '0; end
      for (int p = 0; p < 2; p++) begin
         if (v[p]) begin
            case (a[p])
               3'd0: begin m_rxen[p] = d[p][0]; m_txen[p] = d[p][16]; end
               3'd1: begin m_txmk[p] = d[p][5:0]; m_rxmk[p] = d[p][21:16]; end
               3'd2: c[1-p] = d[p][5:0];
               3'd3: s[p] = d[p][21:16];
               default: ;
            endcase
         end
      end
      for (int q = 0; q < 2; q++) m_flag[q] = s[q] | (m_flag[q] & ~c[q]);
   endtask

   task automatic wr_pair(input bit v0, input logic [2:0] a0, input logic [31:0] d0,
                          input bit v1, input logic [2:0] a1, input logic [31:0] d1);
      @(negedge clk);
      drive(0, v0, 1'b1, a0, d0);
      drive(1, v1, 1'b1, a1, d1);
      @(negedge clk);
      drive(0, 1'b0, 1'b0, 3'd0, 32'd0);
      drive(1, 1'b0, 1'b0, 3'd0, 32'd0);
      model_step(v0, a0, d0, v1, a1, d1);
   endtask

   task automatic wr(input int p, input logic [2:0] a, input logic [31:0] d);
      if (p == 0) wr_pair(1'b1, a, d, 1'b0, 3'd0, 32'd0);
      else        wr_pair(1'b0, 3'd0, 32'd0, 1'b1, a, d);
   endtask

   task automatic rd(input int p, input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      drive(p, 1'b1, 1'b0, a, 32'd0);
      @(negedge clk);
      drive(p, 1'b0, 1'b0, 3'd0, 32'd0);
      v = (p == 0) ? p1_rdata : p2_rdata;
   endtask

   task automatic check_irqs(input string tag);
      check({tag, " R6 p1 rxo"}, {31'd0, p1_irq_rxo}, {31'd0, exp_rxo(0)});
      check({tag, " R6 p2 rxo"}, {31'd0, p2_irq_rxo}, {31'd0, exp_rxo(1)});
      check({tag, " R7 p1 txf"}, {31'd0, p1_irq_txf}, {31'd0, exp_txf(0)});
      check({tag, " R7 p2 txf"}, {31'd0, p2_irq_txf}, {31'd0, exp_txf(1)});
   endtask

   // one idle cycle so registered interrupts settle, then full compare
   task automatic check_all(input string tag);
      logic [31:0] v;
      @(negedge clk);
      check_irqs(tag);
      rd(0, 3'd4, v); check({tag, " R9 p1 status"}, v, exp_stat(0));
      rd(1, 3'd4, v); check({tag, " R9 p2 status"}, v, exp_stat(1));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      void'($urandom(32'd20240611));
      for (int q = 0; q < 2; q++) begin
         m_flag[q] = '0; m_rxen[q] = 0; m_txen[q] = 0; m_rxmk[q] = '1; m_txmk[q] = '1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 irqs", {28'd0, p1_irq_rxo, p1_irq_txf, p2_irq_rxo, p2_irq_txf}, 32'd0);
      for (int p = 0; p < 2; p++) begin
         rd(p, 3'd0, v); check("R1 ctrl", v, 32'd0);
         rd(p, 3'd1, v); check("R1 mask", v, 32'h003F_003F);
         rd(p, 3'd4, v); check("R1 status", v, 32'd0);
      end

      // R8: readback of control and mask, other bits and addresses read 0
      wr(0, 3'd1, 32'hFFC0_FFD5);
      rd(0, 3'd1, v); check("R8 mask readback", v, 32'h0000_0015);
      wr(0, 3'd1, 32'h003F_003F);
      wr(1, 3'd0, 32'hFFFF_FFFF);
      rd(1, 3'd0, v); check("R8 ctrl readback", v, 32'h0001_0001);
      wr(1, 3'd0, 32'd0);
      rd(0, 3'd2, v); check("R8 clear word reads 0", v, 32'd0);
      rd(0, 3'd3, v); check("R8 set word reads 0", v, 32'd0);
      rd(1, 3'd5, v); check("R8 addr 5 reads 0", v, 32'd0);
      rd(1, 3'd7, v); check("R8 addr 7 reads 0", v, 32'd0);

      // R2: processor 1 occupies channels 0 and 2; low-field bits have no effect
      wr(0, 3'd3, 32'h0005_003F);
      check_all("R2 set 0x05");
      rd(1, 3'd4, v); check("R2 receiver sees flags", v, 32'h0005_0000);

      // R4: processor 1 clear word cannot free its own transmit flags
      wr(0, 3'd2, 32'h003F_003F);
      rd(0, 3'd4, v); check("R4 own clear leaves tx", v, 32'h0000_0005);
      // R4: processor 2 set word targets only its own direction
      wr(1, 3'd3, 32'h0002_0000);
      rd(1, 3'd4, v); check("R4 p2 set own tx only", v, 32'h0005_0002);
      check_all("R4 cross");

      // R3: processor 2 frees channel 0 only; zero bits leave channel 2
      wr(1, 3'd2, 32'h0004_0001);
      rd(0, 3'd4, v); check("R3 clear ch0", v, 32'h0002_0004);
      check_all("R3");

      // R5: conflict on occupied flag (ch2) and on free flag (ch1)
      wr_pair(1'b1, 3'd3, 32'h0004_0000, 1'b1, 3'd2, 32'h0000_0004);
      rd(0, 3'd4, v); check("R5 occupied stays", v[5:0], 32'h4);
      wr_pair(1'b1, 3'd3, 32'h0002_0000, 1'b1, 3'd2, 32'h0000_0002);
      rd(0, 3'd4, v); check("R5 free becomes occupied", v[5:0], 32'h6);
      wr(1, 3'd2, 32'h0000_0002);
      rd(0, 3'd4, v); check("R5 later clear frees", v[5:0], 32'h4);

      // R9: writes to status are ignored
      wr(0, 3'd4, 32'hFFFF_FFFF);
      rd(0, 3'd4, v); check("R9 status write ignored", v, exp_stat(0));

      // R6: processor 2 rxo, exact cycle of rise
      wr(1, 3'd1, 32'h003B_003F);          // unmask rx channel 2
      wr(1, 3'd0, 32'h0000_0001);          // flag edge just passed; irq not yet
      check("R6 rxo not yet", {31'd0, p2_irq_rxo}, 32'd0);
      @(negedge clk);
      check("R6 rxo one cycle later", {31'd0, p2_irq_rxo}, 32'd1);
      wr(1, 3'd2, 32'h0000_0004);          // free channel 2
      check("R6 rxo still high", {31'd0, p2_irq_rxo}, 32'd1);
      @(negedge clk);
      check("R6 rxo drops", {31'd0, p2_irq_rxo}, 32'd0);

      // R7: processor 1 txf on channel 3 (free), then occupy it
      wr(0, 3'd1, 32'h003F_0037);
      wr(0, 3'd0, 32'h0001_0000);
      @(negedge clk);
      check("R7 txf high", {31'd0, p1_irq_txf}, 32'd1);
      wr(0, 3'd3, 32'h0008_0000);
      check("R7 txf still high", {31'd0, p1_irq_txf}, 32'd1);
      @(negedge clk);
      check("R7 txf drops", {31'd0, p1_irq_txf}, 32'd0);
      check_all("R7 directed");

      // random phase over all addresses and both ports
      for (int it = 0; it < 300; it++) begin
         logic [2:0]  a0, a1;
         logic [31:0] d0, d1;
         a0 = 3'($urandom % 5); a1 = 3'($urandom % 5);
         d0 = $urandom; d1 = $urandom;
         if (a0 == 3'd1) d0[21:16] = d0[21:16] & 6'($urandom);
         if (($urandom % 4) == 0) wr_pair(1'b1, a0, d0, 1'b1, a1, d1);
         else if ($urandom % 2)   wr(0, a0, d0);
         else                     wr(1, a1, d1);
         check_all("R2 R3 R5 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule